// File: doc/BRIEF.md
# Address Translation Cache with Global Retention

This block caches virtual-to-physical page translations for 4 KB pages in a small fully associative array. A lookup port takes a virtual page number and, one clock later, reports a registered hit together with the physical frame and the write-enable and user-access flags of the matching entry. A walker outside the block loads new translations through a fill port by presenting a virtual page number and a raw 32-bit page table entry. The frame is taken from entry bits 31:12, write-enable from bit 1, user access from bit 2 and the global flag from bit 8.

Two maintenance inputs keep the cache consistent with the page tables. A write to the translation root register drops every entry except those whose global flag is set. A single-page invalidate removes the one entry whose tag matches the given virtual page number, whether or not that entry is global, and no other maintenance input can remove a global entry. A fill whose tag is already resident overwrites that entry in place. Otherwise the fill goes to the lowest-numbered free slot, or to the slot named by a round-robin victim pointer when no slot is free.

Top module: `xlat_cache`

## Requirements
- R1: After reset no lookup hits, and lkpHit is 0 in the first cycle after reset is released.
- R2: lkpHit, lkpFrame, lkpWrite and lkpUser are registered and reflect the lookup VPN presented in the previous cycle. On a hit the frame equals fill PTE bits 31:12, lkpWrite equals PTE bit 1 and lkpUser equals PTE bit 2.
- R3: A fill becomes visible to a lookup presented in the cycle after the fill.
- R4: A root write (rootWr=1) invalidates every entry whose global bit (PTE bit 8) is clear.
- R5: Entries with the global bit set still hit after a root write.
- R6: A single-page invalidate (invVld=1, invVpn) removes only the matching entry, global or not, and all other entries still hit.
- R7: A fill whose VPN matches a valid entry overwrites that entry in place, so no two valid entries share a tag.
- R8: A fill with no tag match writes the lowest-indexed invalid entry. When every entry is valid it writes the entry at the round-robin pointer, which then advances by one and wraps from N-1 to 0.
- R9: When a flush (root write or single-page invalidate) and a fill occur in the same cycle, the flush is applied first and the filled entry is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkpVpn | input | 20 | Virtual page number to look up |
| lkpHit | output | 1 | Registered hit result |
| lkpFrame | output | 20 | Registered physical frame |
| lkpWrite | output | 1 | Registered write-enable flag |
| lkpUser | output | 1 | Registered user-access flag |
| fillVld | input | 1 | Fill strobe |
| fillVpn | input | 20 | Virtual page number of the fill |
| fillPte | input | 32 | Raw page table entry of the fill |
| rootWr | input | 1 | Root register write; flushes non-global entries |
| invVld | input | 1 | Single-page invalidate strobe |
| invVpn | input | 20 | Virtual page number to invalidate |

## Verification
The bench uses the default build with 16 entries and 20-bit page numbers. It keeps its own model of the cache contents, including the free-slot search and the round-robin pointer. With only 16 entries, filling past capacity several times drives the victim pointer through every slot and across its wrap. After every fill, root write, invalidate and combined operation, the bench sweeps every tag it has used and compares hit, frame and flags against the model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int PTE_W = 32;
  localparam int PTE_RW_BIT = 1;
  localparam int PTE_US_BIT = 2;
  localparam int PTE_G_BIT = 8;

  typedef struct packed {
    logic [VPN_W-1:0] tag;
    logic [PFN_W-1:0] frame;
    logic             wr;
    logic             usr;
    logic             glb;
  } entry_t;

  typedef struct packed {
    logic flushNg;
    logic invOne;
    logic fillEn;
    logic advPtr;
  } strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fillVld,
  input  logic                 rootWr,
  input  logic                 invVld,
  input  logic                 fillMatch,
  input  logic [IDX_W-1:0]     matchIdx,
  input  logic [ENTRIES-1:0]   postValid,
  output xlat_pkg::strobe_t    strobes,
  output logic [IDX_W-1:0]     fillIdx
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             haveFree;

  always_comb begin
    freeIdx = '0;
    haveFree = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!postValid[i]) begin
        freeIdx = IDX_W'(i);
        haveFree = 1'b1;
      end
    end
  end

  always_comb begin
    strobes.flushNg = rootWr;
    strobes.invOne  = invVld;
    strobes.fillEn  = fillVld;
    strobes.advPtr  = fillVld && !fillMatch && !haveFree;
    if (fillMatch)     fillIdx = matchIdx;
    else if (haveFree) fillIdx = freeIdx;
    else               fillIdx = rrPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rrPtr <= '0;
    else if (strobes.advPtr) rrPtr <= (rrPtr == IDX_W'(ENTRIES-1)) ? '0 : rrPtr + 1'b1;
  end

  p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    rrPtr <= IDX_W'(ENTRIES-1));
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advPtr |=> (rrPtr == (($past(rrPtr) == IDX_W'(ENTRIES-1)) ? '0 : $past(rrPtr) + 1'b1)));
endmodule

// File: rtl/xlat_array.sv
module xlat_array #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xlat_pkg::strobe_t             strobes,
  input  logic [IDX_W-1:0]              fillIdx,
  input  logic [xlat_pkg::VPN_W-1:0]    fillVpn,
  input  logic [xlat_pkg::PTE_W-1:0]    fillPte,
  input  logic [xlat_pkg::VPN_W-1:0]    invVpn,
  input  logic [xlat_pkg::VPN_W-1:0]    lkpVpn,
  output logic                          fillMatch,
  output logic [IDX_W-1:0]              matchIdx,
  output logic [ENTRIES-1:0]            postValid,
  output logic                          lkpHit,
  output logic [xlat_pkg::PFN_W-1:0]    lkpFrame,
  output logic                          lkpWrite,
  output logic                          lkpUser
);
  import xlat_pkg::*;
  entry_t             ent [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] lkpMatch;
  logic [ENTRIES-1:0] fMatch;
  entry_t             newEnt;

  assign newEnt.tag   = fillVpn;
  assign newEnt.frame = fillPte[PTE_W-1:PTE_W-PFN_W];
  assign newEnt.wr    = fillPte[PTE_RW_BIT];
  assign newEnt.usr   = fillPte[PTE_US_BIT];
  assign newEnt.glb   = fillPte[PTE_G_BIT];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    logic killG, killI;
    assign killG = strobes.flushNg && !ent[g].glb;
    assign killI = strobes.invOne && (ent[g].tag == invVpn);
    assign postValid[g] = valid[g] && !killG && !killI;
    assign fMatch[g]   = postValid[g] && (ent[g].tag == fillVpn);
    assign lkpMatch[g] = valid[g] && (ent[g].tag == lkpVpn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        valid[g] <= 1'b0;
        ent[g]   <= '0;
      end else if (strobes.fillEn && fillIdx == IDX_W'(g)) begin
        valid[g] <= 1'b1;
        ent[g]   <= newEnt;
      end else begin
        valid[g] <= postValid[g];
      end
    end
  end

  always_comb begin
    fillMatch = |fMatch;
    matchIdx = '0;
    for (int i = 0; i < ENTRIES; i++) if (fMatch[i]) matchIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkpHit <= 1'b0; lkpFrame <= '0; lkpWrite <= 1'b0; lkpUser <= 1'b0;
    end else begin
      lkpHit <= |lkpMatch;
      lkpFrame <= '0; lkpWrite <= 1'b0; lkpUser <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (lkpMatch[i]) begin
          lkpFrame <= ent[i].frame; lkpWrite <= ent[i].wr; lkpUser <= ent[i].usr;
        end
      end
    end
  end

  p_no_dup_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lkpMatch) <= 1);
  p_fill_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillEn |=> valid[$past(fillIdx)]);
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkpHit |-> (lkpFrame == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [19:0] lkpVpn,
  output logic        lkpHit,
  output logic [19:0] lkpFrame,
  output logic        lkpWrite,
  output logic        lkpUser,
  input  logic        fillVld,
  input  logic [19:0] fillVpn,
  input  logic [31:0] fillPte,
  input  logic        rootWr,
  input  logic        invVld,
  input  logic [19:0] invVpn
);
  xlat_pkg::strobe_t  strobes;
  logic [IDX_W-1:0]   fillIdx, matchIdx;
  logic               fillMatch;
  logic [ENTRIES-1:0] postValid;

  xlat_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk, .rstN, .fillVld, .rootWr, .invVld, .fillMatch, .matchIdx,
    .postValid, .strobes, .fillIdx);

  xlat_array #(.ENTRIES(ENTRIES)) uArr (
    .clk, .rstN, .strobes, .fillIdx, .fillVpn, .fillPte, .invVpn, .lkpVpn,
    .fillMatch, .matchIdx, .postValid, .lkpHit, .lkpFrame, .lkpWrite, .lkpUser);

  p_reset_miss_r1: assert property (@(posedge clk) $past(!rstN) |-> !lkpHit);
endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  logic clk = 0, rstN = 0;
  logic [19:0] lkpVpn = 0, fillVpn = 0, invVpn = 0;
  logic [31:0] fillPte = 0;
  logic fillVld = 0, rootWr = 0, invVld = 0;
  logic lkpHit, lkpWrite, lkpUser;
  logic [19:0] lkpFrame;
  int checks = 0, errors = 0;

  logic        mV [N];
  logic [19:0] mT [N];
  logic [31:0] mP [N];
  int          rr;

  xlat_cache dut (.*);
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] pteOf(int k, bit g);
    return {20'(k*37 + 5), 3'b0, g, 5'b0, 1'(k >> 1), 1'(k), 1'b1};
  endfunction

  task automatic modelOp(bit f, logic [19:0] v, logic [31:0] p, bit r, bit iv, logic [19:0] ivp);
    int idx = -1;
    for (int i = 0; i < N; i++) begin
      if (r && !mP[i][8]) mV[i] = 0;
      if (iv && mT[i] == ivp) mV[i] = 0;
    end
    if (f) begin
      for (int i = 0; i < N; i++) if (mV[i] && mT[i] == v) idx = i;
      if (idx < 0) for (int i = N-1; i >= 0; i--) if (!mV[i]) idx = i;
      if (idx < 0) begin idx = rr; rr = (rr + 1) % N; end
      mV[idx] = 1; mT[idx] = v; mP[idx] = p;
    end
  endtask

  task automatic op(bit f, logic [19:0] v, logic [31:0] p, bit r, bit iv, logic [19:0] ivp);
    fillVld = f; fillVpn = v; fillPte = p; rootWr = r; invVld = iv; invVpn = ivp;
    @(posedge clk); #1;
    fillVld = 0; rootWr = 0; invVld = 0;
    modelOp(f, v, p, r, iv, ivp);
  endtask

  task automatic look(logic [19:0] v, string req);
    int idx = -1;
    lkpVpn = v;
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) if (mV[i] && mT[i] == v) idx = i;
    checks++;
    if (idx < 0) begin
      if (lkpHit !== 0) begin
        errors++;
        $display("FAIL %s vpn=%h actual hit=%b expected hit=0", req, v, lkpHit);
      end
    end else if (lkpHit !== 1 || lkpFrame !== mP[idx][31:12] ||
                 lkpWrite !== mP[idx][1] || lkpUser !== mP[idx][2]) begin
      errors++;
      $display("FAIL %s vpn=%h actual hit=%b frm=%h w=%b u=%b expected hit=1 frm=%h w=%b u=%b",
               req, v, lkpHit, lkpFrame, lkpWrite, lkpUser, mP[idx][31:12], mP[idx][1], mP[idx][2]);
    end
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 40; k++) look(20'(k*3 + 100), req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mV[i] = 0; mT[i] = 0; mP[i] = 0; end
    rr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    checks++;
    if (lkpHit !== 0) begin errors++; $display("FAIL R1 actual hit=%b expected 0", lkpHit); end
    sweep("R1");
    // R2/R3: partial fill, mix of global
    for (int k = 0; k < 10; k++) begin
      op(1, 20'(k*3+100), pteOf(k, k%3==0), 0, 0, 0);
      look(20'(k*3+100), "R3");
    end
    sweep("R2");
    // R8: overflow cache, pointer wraps
    for (int k = 10; k < 40; k++) op(1, 20'(k*3+100), pteOf(k, k%4==0), 0, 0, 0);
    sweep("R8");
    // R7: refill resident tag in place
    op(1, 20'(39*3+100), pteOf(77, 0), 0, 0, 0);
    sweep("R7");
    // R6: invalidate one global and one non-global
    op(0, 0, 0, 0, 1, 20'(36*3+100));
    sweep("R6");
    op(0, 0, 0, 0, 1, 20'(39*3+100));
    sweep("R6");
    // R4/R5: root write
    op(0, 0, 0, 1, 0, 0);
    sweep("R4");
    sweep("R5");
    // R8: free slots reused lowest first
    for (int k = 0; k < 8; k++) op(1, 20'(k*3+100), pteOf(k+50, 0), 0, 0, 0);
    sweep("R8");
    // R9: flush and fill together
    op(1, 20'(5*3+100), pteOf(90, 0), 1, 0, 0);
    sweep("R9");
    op(1, 20'(32*3+100), pteOf(91, 1), 0, 1, 20'(32*3+100));
    sweep("R9");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule